// File: doc/BRIEF.md
# Sleep Debug Handshake Sequencer

This block lets an attached debugger keep control of a multi-core subsystem across a low-power sleep cycle. When software asks for sleep while low-power debug is enabled, the sequencer raises a sync flag toward the debug tool. It holds off sleep entry until the tool clears that flag with a write of 1. The enable is captured at the moment sleep is entered. That captured copy alone decides what happens at wakeup.

On a wakeup with the captured enable set, the sequencer requests debug mode from every core. During that phase it steers the core debug clock to the internal oscillator. When all cores acknowledge, it returns the clock to the external test clock, enables the JTAG pins and drives the data-out pin. On any sleep exit it pulses a load strobe, and each core then takes its restart address from a per-core wake vector register. A general-purpose retention register keeps its value through sleep for use by recovery code.

Top module: `lpdbg_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all control outputs are 0, lp_dbg_latched is 0, and keep_val and pc_vec read 0.
- R2: A sleep_req seen in the running state with dbg_en = 1 sets sync_flag from the next cycle. While sync_flag is 1, sleep_grant stays 0.
- R3: A sync_clr strobe clears sync_flag at the next edge. sleep_grant rises one cycle after sync_flag first reads 0, so it rises two edges after the strobe.
- R4: A sleep_req seen in the running state with dbg_en = 0 raises sleep_grant at the next edge, and sync_flag stays 0.
- R5: lp_dbg_latched takes the value of dbg_en at the edge where sleep_grant rises. Later changes of dbg_en leave it unchanged until the next sleep entry.
- R6: A wake pulse during sleep with lp_dbg_latched = 0 drops sleep_grant at the next edge and returns to running, with dbg_req = 0 and clk_sel_irc = 0.
- R7: A wake pulse during sleep with lp_dbg_latched = 1 raises all bits of dbg_req and clk_sel_irc (1 = internal oscillator) at the next edge.
- R8: dbg_req and clk_sel_irc stay asserted while any bit of core_ack is 0.
- R9: One edge after all core_ack bits are 1 (while waiting for acknowledge), dbg_req and clk_sel_irc drop and jtag_pin_en and tdo_drive rise. Both stay 1 until the next sleep entry clears them.
- R10: pc_load is a one-cycle pulse in the cycle after the wake edge on every sleep exit. pc_vec holds core i's wake vector in bits [i*VEC_W +: VEC_W].
- R11: A write with cfg_we = 1 stores cfg_wdata into wake vector i when cfg_sel = i (i < NCORE), or into keep_val when cfg_sel = NCORE. Any other cfg_sel value changes nothing. keep_val holds its value across sleep.
- R12: sleep_grant stays 1 until a wake pulse, and a sleep_req raised during sleep has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Request to enter sleep |
| dbg_en | input | 1 | Low-power debug enable |
| sync_clr | input | 1 | Write-1-to-clear strobe for sync_flag |
| wake | input | 1 | Wakeup event |
| core_ack | input | NCORE | Per-core debug-mode acknowledge (level) |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | $clog2(NCORE+1) | Register select: wake vectors, then retention |
| cfg_wdata | input | VEC_W | Register write data |
| sync_flag | output | 1 | Sleep-sync flag toward the debug tool |
| sleep_grant | output | 1 | Sleep is in effect |
| lp_dbg_latched | output | 1 | Enable captured at sleep entry |
| dbg_req | output | NCORE | Debug-mode request per core |
| clk_sel_irc | output | 1 | Debug clock select, 1 = internal oscillator |
| jtag_pin_en | output | 1 | JTAG pin enable |
| tdo_drive | output | 1 | Data-out pin driven asserted |
| pc_load | output | 1 | Restart vector load strobe |
| pc_vec | output | NCORE*VEC_W | Wake vectors, one field per core |
| keep_val | output | VEC_W | Retention register |

## Verification
A wrong state shows at the ports within one edge. A missed sync wait shows as sleep_grant rising while sync_flag is still 1, or rising a cycle early. A bad wake branch shows as dbg_req appearing or missing in the cycle after wake. A release on a partial acknowledge shows as jtag_pin_en rising too soon. A stale captured enable shows as the wrong wake path, either on the next sleep cycle or on lp_dbg_latched at once. The bench compares every control output in every cycle against its expectation, and compares the register outputs at the points where they should have changed or held.

// File: rtl/lpdbg_pkg.sv
`timescale 1ns/1ps
// Shared types for the sleep debug handshake sequencer.
// Assumes: one state machine instance per sequencer.
package lpdbg_pkg;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_SYNC_WAIT  = 3'd1,
        ST_SLEEP      = 3'd2,
        ST_WAKE_DEBUG = 3'd3,
        ST_WAIT_ACK   = 3'd4,
        ST_HANDOVER   = 3'd5
    } seq_state_t;

    // True while cores are being forced into debug on the internal clock.
    function automatic logic in_debug_phase(input seq_state_t s);
        return (s == ST_WAKE_DEBUG) || (s == ST_WAIT_ACK);
    endfunction

endpackage

// File: rtl/lpdbg_sync_flag.sv
`timescale 1ns/1ps
// Sleep-sync status bit. Hardware sets it. A bus write of 1 clears it.
// Assumes: a set and a clear in the same cycle resolve to set.
module lpdbg_sync_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Hold the flag: set has priority over the write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R2

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o); // R3

endmodule

// File: rtl/lpdbg_fsm.sv
`timescale 1ns/1ps
// Sequencer state machine and the enable captured at sleep entry.
// Assumes: acknowledges are levels. wake is only acted on in sleep.
module lpdbg_fsm
    import lpdbg_pkg::*;
#(
    parameter int NCORE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req_i,
    input  logic             dbg_en_i,
    input  logic             sync_flag_i,
    input  logic             wake_i,
    input  logic [NCORE-1:0] ack_i,
    output seq_state_t       state_o,
    output logic             sync_set_o,
    output logic             enter_sleep_o,
    output logic             exit_sleep_o,
    output logic             latched_o
);

    seq_state_t state_q, state_d;
    logic       latched_q;
    logic       all_ack;

    assign all_ack = &ack_i;

    // Next-state and transition strobes.
    always_comb begin
        state_d       = state_q;
        sync_set_o    = 1'b0;
        enter_sleep_o = 1'b0;
        exit_sleep_o  = 1'b0;
        case (state_q)
            ST_RUN: begin
                if (sleep_req_i) begin
                    if (dbg_en_i) begin
                        state_d    = ST_SYNC_WAIT;
                        sync_set_o = 1'b1;
                    end else begin
                        state_d       = ST_SLEEP;
                        enter_sleep_o = 1'b1;
                    end
                end
            end
            ST_SYNC_WAIT: begin
                if (!sync_flag_i) begin
                    state_d       = ST_SLEEP;
                    enter_sleep_o = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (wake_i) begin
                    exit_sleep_o = 1'b1;
                    state_d      = latched_q ? ST_WAKE_DEBUG : ST_RUN;
                end
            end
            ST_WAKE_DEBUG: state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (all_ack) state_d = ST_HANDOVER;
            end
            ST_HANDOVER: state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Capture the debug enable at the moment sleep is entered.
    always_ff @(posedge clk) begin
        if (!rst_n)             latched_q <= 1'b0;
        else if (enter_sleep_o) latched_q <= dbg_en_i;
    end

    assign state_o   = state_q;
    assign latched_o = latched_q;

    AST_GRANT_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && $past(state_q) == ST_SYNC_WAIT) |-> !$past(sync_flag_i)); // R3

    AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && $past(state_q) == ST_SLEEP) |-> $stable(latched_q)); // R5

    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && wake_i) |=> (state_q != ST_SLEEP)); // R12

    AST_WAKE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && wake_i && !latched_q) |=> (state_q == ST_RUN)); // R6

endmodule

// File: rtl/lpdbg_pin_ctl.sv
`timescale 1ns/1ps
// Output stage: debug requests, clock select, sticky pin enables and load strobe.
// Assumes: pin enables last from handover until the next sleep entry.
module lpdbg_pin_ctl
    import lpdbg_pkg::*;
#(
    parameter int NCORE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_t       state_i,
    input  logic             enter_sleep_i,
    input  logic             exit_sleep_i,
    output logic [NCORE-1:0] dbg_req_o,
    output logic             clk_sel_irc_o,
    output logic             pin_en_o,
    output logic             pc_load_o
);

    logic pin_q;
    logic pc_load_q;
    logic dbg_phase;

    assign dbg_phase = in_debug_phase(state_i);

    // Keep the JTAG pins enabled after handover until sleep is entered again.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pin_q <= 1'b0;
        else if (enter_sleep_i)          pin_q <= 1'b0;
        else if (state_i == ST_HANDOVER) pin_q <= 1'b1;
    end

    // One-cycle restart-vector load strobe after each sleep exit.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_load_q <= 1'b0;
        else        pc_load_q <= exit_sleep_i;
    end

    // Replicate the debug request to every core.
    for (genvar i = 0; i < NCORE; i++) begin : g_req
        assign dbg_req_o[i] = dbg_phase;
    end

    assign clk_sel_irc_o = dbg_phase;
    assign pin_en_o      = pin_q || (state_i == ST_HANDOVER);
    assign pc_load_o     = pc_load_q;

    AST_PC_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !pc_load_o); // R10

    AST_PINS_OFF_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_SLEEP) |-> !pin_en_o); // R9

endmodule

// File: rtl/lpdbg_vec_bank.sv
`timescale 1ns/1ps
// Per-core wake vectors and a retention register, written through a select.
// Assumes: unmapped select values are ignored. Contents are not touched by sleep.
module lpdbg_vec_bank #(
    parameter int NCORE = 2,
    parameter int VEC_W = 32,
    localparam int SEL_W = $clog2(NCORE + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [SEL_W-1:0]       sel_i,
    input  logic [VEC_W-1:0]       wdata_i,
    output logic [NCORE*VEC_W-1:0] vec_o,
    output logic [VEC_W-1:0]       keep_o
);

    logic [VEC_W-1:0] keep_q;

    // One wake vector register per core.
    for (genvar i = 0; i < NCORE; i++) begin : g_vec
        logic [VEC_W-1:0] vec_q;

        // Store the vector when this core's select is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 vec_q <= '0;
            else if (we_i && sel_i == SEL_W'(i))        vec_q <= wdata_i;
        end

        assign vec_o[i*VEC_W +: VEC_W] = vec_q;
    end

    // Retention register at the select just above the vectors.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   keep_q <= '0;
        else if (we_i && sel_i == SEL_W'(NCORE))      keep_q <= wdata_i;
    end

    assign keep_o = keep_q;

    AST_KEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(keep_o)); // R11

endmodule

// File: rtl/lpdbg_seq.sv
`timescale 1ns/1ps
// Sleep debug handshake sequencer top: the sync flag, state machine,
// output stage and vector bank.
// Assumes: the JTAG TAP and the cores sit outside and consume these outputs.
module lpdbg_seq
    import lpdbg_pkg::*;
#(
    parameter int NCORE = 2,
    parameter int VEC_W = 32,
    localparam int SEL_W = $clog2(NCORE + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sleep_req,
    input  logic                   dbg_en,
    input  logic                   sync_clr,
    input  logic                   wake,
    input  logic [NCORE-1:0]       core_ack,
    input  logic                   cfg_we,
    input  logic [SEL_W-1:0]       cfg_sel,
    input  logic [VEC_W-1:0]       cfg_wdata,
    output logic                   sync_flag,
    output logic                   sleep_grant,
    output logic                   lp_dbg_latched,
    output logic [NCORE-1:0]       dbg_req,
    output logic                   clk_sel_irc,
    output logic                   jtag_pin_en,
    output logic                   tdo_drive,
    output logic                   pc_load,
    output logic [NCORE*VEC_W-1:0] pc_vec,
    output logic [VEC_W-1:0]       keep_val
);

    seq_state_t state;
    logic       sync_set;
    logic       enter_sleep;
    logic       exit_sleep;
    logic       pin_en;

    lpdbg_sync_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sync_set),
        .clr_i  (sync_clr),
        .flag_o (sync_flag)
    );

    lpdbg_fsm #(.NCORE(NCORE)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_req_i   (sleep_req),
        .dbg_en_i      (dbg_en),
        .sync_flag_i   (sync_flag),
        .wake_i        (wake),
        .ack_i         (core_ack),
        .state_o       (state),
        .sync_set_o    (sync_set),
        .enter_sleep_o (enter_sleep),
        .exit_sleep_o  (exit_sleep),
        .latched_o     (lp_dbg_latched)
    );

    lpdbg_pin_ctl #(.NCORE(NCORE)) u_pins (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_i       (state),
        .enter_sleep_i (enter_sleep),
        .exit_sleep_i  (exit_sleep),
        .dbg_req_o     (dbg_req),
        .clk_sel_irc_o (clk_sel_irc),
        .pin_en_o      (pin_en),
        .pc_load_o     (pc_load)
    );

    lpdbg_vec_bank #(.NCORE(NCORE), .VEC_W(VEC_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .sel_i   (cfg_sel),
        .wdata_i (cfg_wdata),
        .vec_o   (pc_vec),
        .keep_o  (keep_val)
    );

    assign sleep_grant = (state == ST_SLEEP);
    assign jtag_pin_en = pin_en;
    assign tdo_drive   = pin_en;

    AST_NO_GRANT_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sync_flag |-> !sleep_grant); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req != '0 && !(&core_ack)) |=> (dbg_req == '1 && clk_sel_irc)); // R8

    AST_PINS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jtag_pin_en) |-> $past(&core_ack)); // R9

    AST_NO_IRC_WITH_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_sel_irc && jtag_pin_en)); // R9

    AST_WAKE_DEBUG_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_grant && wake && lp_dbg_latched) |=> (dbg_req == '1 && clk_sel_irc)); // R7

endmodule

// File: tb/sim_lpdbg_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected outputs for each cycle,
// and the monitor pops them and compares them 5 ns after the rising edge.
module sim_lpdbg_seq;

    localparam int NCORE = 2;
    localparam int VEC_W = 32;
    localparam int VW    = 9 + VEC_W + NCORE*VEC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sleep_req = 1'b0, dbg_en = 1'b0, sync_clr = 1'b0, wake = 1'b0;
    logic [NCORE-1:0]  core_ack = '0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [VEC_W-1:0]  cfg_wdata = '0;
    logic              sync_flag, sleep_grant, lp_dbg_latched, clk_sel_irc;
    logic              jtag_pin_en, tdo_drive, pc_load;
    logic [NCORE-1:0]  dbg_req;
    logic [NCORE*VEC_W-1:0] pc_vec;
    logic [VEC_W-1:0]  keep_val;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [VW-1:0] exp_q[$];
    logic [VW-1:0] msk_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;

    lpdbg_seq #(.NCORE(NCORE), .VEC_W(VEC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .dbg_en(dbg_en),
        .sync_clr(sync_clr), .wake(wake), .core_ack(core_ack),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .sync_flag(sync_flag), .sleep_grant(sleep_grant),
        .lp_dbg_latched(lp_dbg_latched), .dbg_req(dbg_req),
        .clk_sel_irc(clk_sel_irc), .jtag_pin_en(jtag_pin_en),
        .tdo_drive(tdo_drive), .pc_load(pc_load), .pc_vec(pc_vec),
        .keep_val(keep_val)
    );

    // Pack the expected control outputs; tdo_drive follows the pin enable.
    function automatic logic [8:0] c(input logic sf, sg, input logic [1:0] dr,
                                     input logic irc, pin, pl, lat);
        return {sf, sg, dr, irc, pin, pin, pl, lat};
    endfunction

    // Driver: push the expectation for the coming edge, then move to the next falling edge.
    task automatic tick(input logic [8:0] ctl, input logic chk_data,
                        input logic [VEC_W-1:0] kv, input logic [NCORE*VEC_W-1:0] vv,
                        input string tag);
        exp_q.push_back({ctl, kv, vv});
        msk_q.push_back(chk_data ? {VW{1'b1}} : {9'h1FF, {(VW-9){1'b0}}});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: compare the outputs against the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [VW-1:0] ev, em, got;
                string t;
                ev  = exp_q.pop_front();
                em  = msk_q.pop_front();
                t   = tag_q.pop_front();
                got = {sync_flag, sleep_grant, dbg_req, clk_sel_irc, jtag_pin_en,
                       tdo_drive, pc_load, lp_dbg_latched, keep_val, pc_vec};
                vectors++;
                if (((got ^ ev) & em) !== '0) begin
                    miscompares++;
                    $display("FAIL %s: actual %h expected %h (mask %h)", t, got, ev, em);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(c(0,0,2'b00,0,0,0,0), 1, '0, '0, "R1 reset state");

        // R11: register writes, including an unmapped select.
        cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = 32'hA000_0100;
        tick(c(0,0,2'b00,0,0,0,0), 0, '0, '0, "R11 write vec0");
        cfg_sel = 2'd1; cfg_wdata = 32'hB100_0200;
        tick(c(0,0,2'b00,0,0,0,0), 1, '0, {32'hB100_0200, 32'hA000_0100}, "R11 vec1");
        cfg_sel = 2'd2; cfg_wdata = 32'hC2C2_0003;
        tick(c(0,0,2'b00,0,0,0,0), 1, 32'hC2C2_0003, {32'hB100_0200, 32'hA000_0100}, "R11 keep");
        cfg_sel = 2'd3; cfg_wdata = 32'hDEAD_BEEF;
        tick(c(0,0,2'b00,0,0,0,0), 1, 32'hC2C2_0003, {32'hB100_0200, 32'hA000_0100}, "R11 unmapped ignored");
        cfg_we = 0;

        // Sleep without debug.
        sleep_req = 1; dbg_en = 0;
        tick(c(0,1,2'b00,0,0,0,0), 0, '0, '0, "R4 direct sleep");
        sleep_req = 0;
        tick(c(0,1,2'b00,0,0,0,0), 0, '0, '0, "R12 sleep holds");
        wake = 1;
        tick(c(0,0,2'b00,0,0,1,0), 1, 32'hC2C2_0003, {32'hB100_0200, 32'hA000_0100}, "R6 R10 plain wake");
        wake = 0;
        tick(c(0,0,2'b00,0,0,0,0), 1, 32'hC2C2_0003, {32'hB100_0200, 32'hA000_0100}, "R10 R11 pulse ends, keep retained");

        // Sleep with debug.
        dbg_en = 1; sleep_req = 1;
        tick(c(1,0,2'b00,0,0,0,0), 0, '0, '0, "R2 sync flag set");
        sleep_req = 0;
        tick(c(1,0,2'b00,0,0,0,0), 0, '0, '0, "R2 waiting on flag");
        tick(c(1,0,2'b00,0,0,0,0), 0, '0, '0, "R2 still waiting");
        sync_clr = 1;
        tick(c(0,0,2'b00,0,0,0,0), 0, '0, '0, "R3 flag cleared, no grant yet");
        sync_clr = 0;
        tick(c(0,1,2'b00,0,0,0,1), 0, '0, '0, "R3 R5 grant and latch");
        dbg_en = 0; sleep_req = 1;
        tick(c(0,1,2'b00,0,0,0,1), 0, '0, '0, "R5 R12 latch and sleep unaffected");
        sleep_req = 0; wake = 1;
        tick(c(0,0,2'b11,1,0,1,1), 0, '0, '0, "R7 debug wake");
        wake = 0; core_ack = 2'b01;
        tick(c(0,0,2'b11,1,0,0,1), 0, '0, '0, "R8 partial ack core0");
        core_ack = 2'b10;
        tick(c(0,0,2'b11,1,0,0,1), 0, '0, '0, "R8 partial ack core1");
        core_ack = 2'b11;
        tick(c(0,0,2'b00,0,1,0,1), 0, '0, '0, "R9 handover");
        core_ack = 2'b00;
        tick(c(0,0,2'b00,0,1,0,1), 0, '0, '0, "R9 pins held");

        // Debug armed, then dropped before the grant edge.
        dbg_en = 1; sleep_req = 1;
        tick(c(1,0,2'b00,0,1,0,1), 0, '0, '0, "R2 second sync");
        sleep_req = 0; sync_clr = 1; dbg_en = 0;
        tick(c(0,0,2'b00,0,1,0,1), 0, '0, '0, "R3 second clear");
        sync_clr = 0;
        tick(c(0,1,2'b00,0,0,0,0), 0, '0, '0, "R5 R9 latch clear, pins off");
        wake = 1;
        tick(c(0,0,2'b00,0,0,1,0), 0, '0, '0, "R6 no-debug wake");
        wake = 0;
        tick(c(0,0,2'b00,0,0,0,0), 1, 32'hC2C2_0003, {32'hB100_0200, 32'hA000_0100}, "R6 R11 back to run");

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule